// File: doc/BRIEF.md
# Dual Timer Tick Prescaler and Source Selector

This block turns one byte-wide control register into two single-cycle count-enable pulses, one for each of two general-purpose timers. A shared prescaler produces a divided enable from the system clock (ratios 12, 4 or 48). It can instead produce one from an asynchronous external clock, which is resynchronized to the system clock, edge-detected and divided by 8. For each timer a select bit picks between that shared prescaled enable and an enable on every system clock.

A per-timer counter-mode input overrides the select bit. While it is high, that timer's enable comes from the timer's own event input instead: the input is synchronized, and each rising edge gives one pulse. All logic runs on the single system clock, and the outputs are enables rather than derived clocks. The timers and the bus decode sit outside the block. The bus side writes the register through a write strobe and reads it back on a byte-wide output.

Top module: `tmr_clk_sel`

## Requirements
- R1: After a synchronous reset the register reads 0x00, and a timer in prescaled mode gets one pulse every 12 system clocks.
- R2: Prescale code 00 (register bits 1:0) gives one enable pulse every 12 system clocks.
- R3: Prescale code 01 gives one enable pulse every 4 system clocks.
- R4: Prescale code 10 gives one enable pulse every 48 system clocks.
- R5: Prescale code 11 gives one enable pulse for every 8 rising edges of the external clock. The external clock passes through a two-flop synchronizer and a rising-edge detector first, so with a 20-cycle external period the pulses are 160 cycles apart.
- R6: Register bit 3 selects the source for timer 0 and bit 4 selects it for timer 1, each independently of the other. A 0 takes the prescaled enable and a 1 gives an enable on every system clock.
- R7: While a timer's counter-mode input is 1, its select bit is ignored and its output pulses once for each rising edge of its event input. The pulse appears on the second system clock after the edge is sampled.
- R8: Register bits 7:5 and bit 2 always read 0, and writing them has no effect. Writing 0xFF reads back 0x1B.
- R9: A change of prescale code restarts the divider from zero. No pulse comes out in the cycle the new code appears, and the first pulse at ratio N comes N system clocks after the divider restarts.
- R10: A prescaled enable is never high on two consecutive system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 8 | Register write value |
| cfg_rd_data | output | 8 | Register read value |
| ext_clk_in | input | 1 | Asynchronous external clock for the divide-by-8 source |
| tmr_cnt_mode | input | 2 | Per-timer counter-mode override (bit i is timer i) |
| tmr_evt_in | input | 2 | Per-timer asynchronous event input used in counter mode |
| tmr_tick | output | 2 | Per-timer single-cycle count enable |

## Verification
Each of the four prescale codes runs with both timers on the prescaled source. The measured spacing between pulses separates the three system-clock ratios from one another and from the 160-cycle external case. The select bits are then set one at a time, which shows that each acts only on its own timer, and a mid-count code change shows whether the divider restarted or leaked an early pulse at the old ratio. Counter mode is driven with single event pulses while the select bit is 1, so a timer that still ticked every clock is told apart from one that follows its event input.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    typedef enum logic [1:0] {
        PS_DIV_A   = 2'b00,
        PS_DIV_B   = 2'b01,
        PS_DIV_C   = 2'b10,
        PS_EXT_DIV = 2'b11
    } ps_code_e;

    typedef struct packed {
        logic     fast1;
        logic     fast0;
        ps_code_e code;
    } tcs_cfg_t;

    localparam logic [7:0] CFG_RW_MASK = 8'h1B;

    function automatic tcs_cfg_t unpack_cfg(input logic [7:0] b);
        tcs_cfg_t c;
        c.fast1 = b[4];
        c.fast0 = b[3];
        c.code  = ps_code_e'(b[1:0]);
        return c;
    endfunction

    function automatic logic [7:0] pack_cfg(input tcs_cfg_t c);
        return {3'b000, c.fast1, c.fast0, 1'b0, c.code};
    endfunction

    function automatic int unsigned ratio_of(input ps_code_e code,
                                             input int unsigned ra,
                                             input int unsigned rb,
                                             input int unsigned rc,
                                             input int unsigned re);
        case (code)
            PS_DIV_A: return ra;
            PS_DIV_B: return rb;
            PS_DIV_C: return rc;
            default:  return re;
        endcase
    endfunction

endpackage

// File: rtl/tcs_sync_edge.sv
module tcs_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= async_in;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else     chain[g] <= chain[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b0;
        else     last <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/tcs_cfg_reg.sv
module tcs_cfg_reg
    import tcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output tcs_cfg_t   cfg,
    output logic [7:0] rd_data
);
    tcs_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)        cfg_q <= unpack_cfg(8'h00);
        else if (wr_en) cfg_q <= unpack_cfg(wr_data & CFG_RW_MASK);
    end

    assign cfg     = cfg_q;
    assign rd_data = pack_cfg(cfg_q);
endmodule

// File: rtl/tcs_prescaler.sv
module tcs_prescaler
    import tcs_pkg::*;
#(
    parameter int RATIO_A   = 12,
    parameter int RATIO_B   = 4,
    parameter int RATIO_C   = 48,
    parameter int RATIO_EXT = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  ps_code_e code,
    input  logic     ext_rise,
    output logic     pulse
);
    localparam int MAX_AB = (RATIO_A > RATIO_B) ? RATIO_A : RATIO_B;
    localparam int MAX_CE = (RATIO_C > RATIO_EXT) ? RATIO_C : RATIO_EXT;
    localparam int MAX_R  = (MAX_AB > MAX_CE) ? MAX_AB : MAX_CE;
    localparam int CNT_W  = (MAX_R > 2) ? $clog2(MAX_R) : 1;

    ps_code_e           active;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   last_val;
    logic               step;
    logic               wrap;
    logic               changed;

    assign changed  = (code != active);
    assign step     = (active == PS_EXT_DIV) ? ext_rise : 1'b1;
    assign last_val = CNT_W'(ratio_of(active, RATIO_A, RATIO_B, RATIO_C, RATIO_EXT) - 1);
    assign wrap     = step && (cnt == last_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= PS_DIV_A;
            cnt    <= '0;
        end else if (changed) begin
            active <= code;
            cnt    <= '0;
        end else if (step) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end

    assign pulse = wrap && !changed;
endmodule

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel
    import tcs_pkg::*;
#(
    parameter int RATIO_A     = 12,
    parameter int RATIO_B     = 4,
    parameter int RATIO_C     = 48,
    parameter int RATIO_EXT   = 8,
    parameter int SYNC_STAGES = 2,
    parameter int N_TMR       = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr_en,
    input  logic [7:0]       cfg_wr_data,
    output logic [7:0]       cfg_rd_data,
    input  logic             ext_clk_in,
    input  logic [N_TMR-1:0] tmr_cnt_mode,
    input  logic [N_TMR-1:0] tmr_evt_in,
    output logic [N_TMR-1:0] tmr_tick
);
    tcs_cfg_t          cfg;
    logic              ext_rise;
    logic              ps_pulse;
    logic [N_TMR-1:0]  evt_rise;
    logic [N_TMR-1:0]  fast_sel;

    tcs_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .cfg     (cfg),
        .rd_data (cfg_rd_data)
    );

    tcs_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ext_clk_in),
        .rise     (ext_rise)
    );

    tcs_prescaler #(
        .RATIO_A   (RATIO_A),
        .RATIO_B   (RATIO_B),
        .RATIO_C   (RATIO_C),
        .RATIO_EXT (RATIO_EXT)
    ) u_ps (
        .clk      (clk),
        .rst      (rst),
        .code     (cfg.code),
        .ext_rise (ext_rise),
        .pulse    (ps_pulse)
    );

    always_comb begin
        fast_sel    = '0;
        fast_sel[0] = cfg.fast0;
        if (N_TMR > 1) fast_sel[N_TMR-1] = cfg.fast1;
    end

    genvar t;
    generate
        for (t = 0; t < N_TMR; t++) begin : g_tmr
            tcs_sync_edge #(.STAGES(SYNC_STAGES)) u_evt_sync (
                .clk      (clk),
                .rst      (rst),
                .async_in (tmr_evt_in[t]),
                .rise     (evt_rise[t])
            );

            always_comb begin
                if (tmr_cnt_mode[t])  tmr_tick[t] = evt_rise[t];
                else if (fast_sel[t]) tmr_tick[t] = 1'b1;
                else                  tmr_tick[t] = ps_pulse;
            end
        end
    endgenerate
endmodule

// File: rtl/tcs_checker.sv
module tcs_checker (
    input logic       clk,
    input logic       rst,
    input logic [7:0] rd,
    input logic [1:0] mode,
    input logic [1:0] tick
);
    AST_RESET_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> rd == 8'h00); // R1

    AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd & 8'hE4) == 8'h00); // R8

    AST_FAST0_EVERY_CLK: assert property (@(posedge clk) disable iff (rst)
        (!mode[0] && rd[3]) |-> tick[0]); // R6

    AST_FAST1_EVERY_CLK: assert property (@(posedge clk) disable iff (rst)
        (!mode[1] && rd[4]) |-> tick[1]); // R6

    AST_PRESCALED_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (!mode[0] && !rd[3] && tick[0]) |=> (!tick[0] || rd[3] || mode[0])); // R10

    AST_EVENT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (mode[1] && tick[1]) |=> !(mode[1] && tick[1])); // R7

    AST_CODE_CHANGE_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((rd[1:0] != $past(rd[1:0])) && !mode[0] && !rd[3]) |-> !tick[0]); // R9
endmodule

bind tmr_clk_sel tcs_checker u_tcs_checker (
    .clk  (clk),
    .rst  (rst),
    .rd   (cfg_rd_data),
    .mode (tmr_cnt_mode),
    .tick (tmr_tick)
);

// File: tb/tmr_clk_sel_bench.sv
`timescale 1ns/1ps
module tmr_clk_sel_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr_en = 1'b0;
    logic [7:0] cfg_wr_data = 8'h00;
    logic [7:0] cfg_rd_data;
    logic       ext_clk_in = 1'b0;
    logic [1:0] tmr_cnt_mode = 2'b00;
    logic [1:0] tmr_evt_in = 2'b00;
    logic [1:0] tmr_tick;
    logic       ext_run = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    tmr_clk_sel u_tmr_clk_sel (
        .clk          (clk),
        .rst          (rst),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_wr_data  (cfg_wr_data),
        .cfg_rd_data  (cfg_rd_data),
        .ext_clk_in   (ext_clk_in),
        .tmr_cnt_mode (tmr_cnt_mode),
        .tmr_evt_in   (tmr_evt_in),
        .tmr_tick     (tmr_tick)
    );

    // ---------------- reference model ----------------
    logic [7:0] m_reg;
    int         m_code, m_cnt;
    bit         xh0, xh1, xh2;
    bit [1:0]   eh0, eh1, eh2;

    function automatic int ratio(input int c);
        case (c)
            0: return 12;
            1: return 4;
            2: return 48;
            default: return 8;
        endcase
    endfunction

    function automatic bit m_pulse();
        bit st;
        st = (m_code == 3) ? (xh1 && !xh2) : 1'b1;
        return st && (m_cnt == ratio(m_code) - 1) && (int'(m_reg[1:0]) == m_code);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_reg = 8'h00; m_code = 0; m_cnt = 0;
            xh0 = 0; xh1 = 0; xh2 = 0;
            eh0 = 0; eh1 = 0; eh2 = 0;
        end else begin
            bit st, hit;
            st  = (m_code == 3) ? (xh1 && !xh2) : 1'b1;
            hit = st && (m_cnt == ratio(m_code) - 1);
            if (int'(m_reg[1:0]) != m_code) begin
                m_code = int'(m_reg[1:0]);
                m_cnt  = 0;
            end else if (st) begin
                m_cnt = hit ? 0 : m_cnt + 1;
            end
            if (cfg_wr_en) m_reg = cfg_wr_data & 8'h1B;
            xh2 = xh1; xh1 = xh0; xh0 = ext_clk_in;
            eh2 = eh1; eh1 = eh0; eh0 = tmr_evt_in;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [1:0] exp_t;
            bit p;
            p = m_pulse();
            for (int i = 0; i < 2; i++) begin
                bit sel;
                sel = (i == 0) ? m_reg[3] : m_reg[4];
                if (tmr_cnt_mode[i]) exp_t[i] = eh1[i] && !eh2[i];
                else if (sel)        exp_t[i] = 1'b1;
                else                 exp_t[i] = p;
            end
            n_chk++;
            if (tmr_tick !== exp_t || cfg_rd_data !== m_reg) begin
                n_bad++;
                $display("FAIL R2-model-compare t=%0t tick=%b exp=%b rd=%h exp=%h (R6 R7 R8 R9)",
                         $time, tmr_tick, exp_t, cfg_rd_data, m_reg);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    initial begin
        forever begin
            repeat (10) @(negedge clk);
            if (ext_run) ext_clk_in = ~ext_clk_in;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_data = v;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic wait_tick(input int idx);
        int guard = 0;
        while (!tmr_tick[idx] && guard < 1000) begin
            @(negedge clk); guard++;
        end
    endtask

    task automatic measure(input string req, input int idx, input int exp);
        wait_tick(idx);
        for (int k = 0; k < 3; k++) begin
            int gap = 0;
            do begin
                @(negedge clk); gap++;
            end while (!tmr_tick[idx] && gap < 1000);
            check(req, gap, exp);
        end
    endtask

    task automatic count_ticks(input int idx, input int cycles, output int cnt);
        cnt = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (tmr_tick[idx]) cnt++;
        end
    endtask

    // ---------------- main sequence ----------------
    initial begin
        int c;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset read", int'(cfg_rd_data), 0);
        measure("R1 reset ratio timer0", 0, 12);
        measure("R2 code00 timer1", 1, 12);

        wr(8'h01);
        measure("R3 code01 timer0", 0, 4);
        wr(8'h02);
        measure("R4 code10 timer1", 1, 48);
        measure("R10 code10 timer0", 0, 48);

        ext_run = 1'b1;
        wr(8'h03);
        measure("R5 ext div8 timer0", 0, 160);
        ext_run = 1'b0;

        wr(8'h08);
        count_ticks(0, 30, c);
        check("R6 bit3 timer0 every clock", c, 30);
        count_ticks(1, 36, c);
        check("R6 bit3 leaves timer1 prescaled", c, 3);
        wr(8'h10);
        count_ticks(1, 30, c);
        check("R6 bit4 timer1 every clock", c, 30);

        wr(8'hFF);
        check("R8 reserved bits read zero", int'(cfg_rd_data), 8'h1B);

        wr(8'h02);
        repeat (20) @(negedge clk);
        wr(8'h01);
        c = 0;
        do begin @(negedge clk); c++; end while (!tmr_tick[0] && c < 100);
        check("R9 restart after code change", c, 4);

        wr(8'h18);
        tmr_cnt_mode = 2'b11;
        repeat (3) @(negedge clk);
        tmr_evt_in[0] = 1'b1;
        c = 0;
        do begin @(negedge clk); c++; end while (!tmr_tick[0] && c < 20);
        check("R7 event latency", c, 2);
        count_ticks(0, 20, c);
        check("R7 select ignored in counter mode", c, 0);
        tmr_evt_in[0] = 1'b0;
        for (int k = 0; k < 3; k++) begin
            tmr_evt_in[1] = 1'b1; repeat (4) @(negedge clk);
            tmr_evt_in[1] = 1'b0; repeat (4) @(negedge clk);
        end
        count_ticks(1, 10, c);
        check("R7 idle event no tick", c, 0);
        tmr_cnt_mode = 2'b00;
        repeat (5) @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule